// File: doc/BRIEF.md
# Saturating integrator glitch filter

This block turns one noisy, asynchronous digital line into a clean level for use inside a clocked design. The raw line is first captured by a two-stage synchronizer. The synchronized level then steers an up/down counter. The counter counts up while the level is 1 and down while it is 0, and it stops at both ends instead of wrapping. The output is held in a two-state register. That register moves high only when the counter sits at its ceiling, and moves low only when the counter sits at zero. The output therefore has the full counter span as hysteresis. A burst of noise can move the count, but the output does not move unless the count reaches the opposite end.

The ceiling is the parameter `MAX_COUNT`, with a default of 30, and the counter is as wide as that ceiling needs. Take the default with a 125 MHz clock. A disturbance of up to 200 ns (25 clocks) in either direction leaves the output unchanged. A wanted signal whose period is several microseconds passes with a fixed delay of `MAX_COUNT + 3` clocks per edge.

Top module: `gf_glitch_filter`

## Requirements
- R1: While `rst_n` is low, `clean_o` is 0. Reset also empties the synchronizer and the counter, so a constant 1 applied across the release reaches the output only after the full delay of R2.
- R2: Starting from a settled low state, a 1 on `noisy_i` that is first sampled at clock edge E makes `clean_o` rise at edge E + `MAX_COUNT` + 2. After E + `MAX_COUNT` + 1 edges from E, `clean_o` is still 0.
- R3: The counter saturates and never wraps. It stays at `MAX_COUNT` under a long 1 and at 0 under a long 0. After any high run of `MAX_COUNT` + 2 or more clocks, a low input clears the output after exactly `MAX_COUNT` + 3 clocks.
- R4: `clean_o` goes from 0 to 1 only in the cycle after the counter equals `MAX_COUNT`.
- R5: `clean_o` goes from 1 to 0 only in the cycle after the counter equals 0. From a saturated high state, the fall occurs `MAX_COUNT` + 3 clocks after the input drops.
- R6: An input that flips every clock, so that the count crosses its midpoint (15/16 for the default) back and forth, never toggles `clean_o`.
- R7: Glitches are rejected in both directions. A high pulse shorter than `MAX_COUNT` clocks from the low state leaves `clean_o` at 0. A low pulse shorter than `MAX_COUNT` clocks from the saturated high state leaves `clean_o` at 1. With the defaults this covers 25 clocks (200 ns at 125 MHz).
- R8: Per clock, the counter moves by at most one step and stays within 0 to `MAX_COUNT`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously; release is expected synchronous to `clk` |
| noisy_i | input | 1 | Raw asynchronous line to be cleaned |
| clean_o | output | 1 | Filtered level, with hysteresis |

## Verification
The assertions assume that `rst_n` is released in step with `clk` and that `MAX_COUNT` is at least 1. Under that assumption, the ceiling and floor detectors can never be true together, and every register holds a defined reset value from the first enabled cycle. The bench changes `noisy_i` and `rst_n` only on falling clock edges, which keeps the synchronizer input clean of setup races. This lets the expected edge delays be counted exactly. Pulse lengths are chosen on both sides of the `MAX_COUNT` threshold so that every saturation and hysteresis boundary is reached.

// File: rtl/gf_pkg.sv
package gf_pkg;

  // Two-state output register encoding
  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } lvl_state_e;

endpackage

// File: rtl/gf_sync.sv
// Multi-stage synchronizer: the asynchronous input lands on one flop only.
module gf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] stage_q;

  generate
    if (STAGES < 2) begin : g_bad_depth
      initial $error("gf_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= {stage_q[LAST-1:0], async_i};
    end
  end

  assign sync_o = stage_q[LAST];

endmodule

// File: rtl/gf_integrator.sv
// Saturating up/down counter with ceiling and floor detectors.
module gf_integrator #(
  parameter int MAX_COUNT = 30
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               level_i,
  output logic [$clog2(MAX_COUNT+1)-1:0]     cnt_o,
  output logic                               at_top_o,
  output logic                               at_floor_o
);

  localparam int               CNT_W = $clog2(MAX_COUNT + 1);
  localparam logic [CNT_W-1:0] TOP   = CNT_W'(MAX_COUNT);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign at_top_o   = (cnt_q == TOP);
  assign at_floor_o = (cnt_q == '0);

  // Enable: move only when not already pinned at the end being pushed toward
  assign cnt_en = level_i ? !at_top_o : !at_floor_o;

  always_comb begin
    if (level_i) begin
      cnt_d = cnt_q + ONE;
    end else begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);  // R8

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + ONE) ||
    (cnt_q + ONE == $past(cnt_q)));  // R8

  AST_HOLD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top_o && level_i) |=> (cnt_q == TOP));  // R3

  AST_HOLD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (at_floor_o && !level_i) |=> (cnt_q == '0));  // R3

endmodule

// File: rtl/gf_hyst_latch.sv
// Two-state output register set by the ceiling and cleared by the floor.
module gf_hyst_latch
  import gf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic level_o
);

  lvl_state_e state_q;
  lvl_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      LVL_LOW:  if (set_i) state_d = LVL_HIGH;
      LVL_HIGH: if (clr_i) state_d = LVL_LOW;
      default:  state_d = LVL_LOW;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LVL_LOW;
    end else begin
      state_q <= state_d;
    end
  end

  assign level_o = (state_q == LVL_HIGH);

  AST_RISE_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level_o) |-> $past(set_i));  // R4

  AST_FALL_AT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(level_o) |-> $past(clr_i));  // R5

  AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_i && clr_i));  // R8

endmodule

// File: rtl/gf_glitch_filter.sv
// Top: synchronizer -> saturating integrator -> hysteresis register.
module gf_glitch_filter #(
  parameter int MAX_COUNT   = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic noisy_i,
  output logic clean_o
);

  localparam int CNT_W = $clog2(MAX_COUNT + 1);

  logic             lvl_sync;
  logic [CNT_W-1:0] cnt;
  logic             at_top;
  logic             at_floor;

  gf_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (noisy_i),
    .sync_o  (lvl_sync)
  );

  gf_integrator #(
    .MAX_COUNT (MAX_COUNT)
  ) u_integ (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_i    (lvl_sync),
    .cnt_o      (cnt),
    .at_top_o   (at_top),
    .at_floor_o (at_floor)
  );

  gf_hyst_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (at_top),
    .clr_i   (at_floor),
    .level_o (clean_o)
  );

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |-> !clean_o);  // R1

  AST_OUT_NEEDS_EXTREME: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_o != $past(clean_o)) |-> ($past(cnt) == '0 || $past(cnt) == CNT_W'(MAX_COUNT)));  // R4

endmodule

// File: tb/gf_glitch_filter_tb.sv
module gf_glitch_filter_tb;

  localparam int MAXC = 30;
  localparam int NV   = 20;

  // Each row: input level, clocks to hold it, expected output, requirement
  localparam bit VEC_LVL [NV] = '{0,1,1,0,1,0,0,1,0,1,0,1,0,1,0,1,0,1,0,0};
  localparam int VEC_CYC [NV] = '{5,32,1,3,5,32,1,16,1,1,1,1,1,1,20,40,1,4,32,1};
  localparam bit VEC_EXP [NV] = '{0,0,1,1,1,1,0,0,0,0,0,0,0,0,0,1,1,1,1,0};
  // rows: 0 R1 | 1 R2 not yet | 2 R2 R4 rise | 3,4 R7 low glitch | 5 R5 at floor
  // 6 R5 fall | 7..13 R6 midpoint dither | 14 R3 floor | 15 R3 ceiling
  // 16,17 R7 | 18,19 R3 no wrap after 40 high clocks
  localparam int VEC_REQ [NV] = '{1,2,2,7,7,5,5,6,6,6,6,6,6,6,3,3,7,7,3,3};

  logic clk;
  logic rst_n;
  logic noisy_i;
  logic clean_o;

  int n_chk;
  int n_bad;

  gf_glitch_filter #(.MAX_COUNT(MAXC)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .noisy_i (noisy_i),
    .clean_o (clean_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input logic exp, input string req, input string what);
    n_chk++;
    if (clean_o !== exp) begin
      n_bad++;
      $display("FAIL %s %s: clean_o=%b expected=%b", req, what, clean_o, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    noisy_i = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    n_chk   = 0;
    n_bad   = 0;
    rst_n   = 1'b0;
    noisy_i = 1'b0;
    repeat (3) @(negedge clk);
    check(1'b0, "R1", "output during reset");
    rst_n = 1'b1;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      hold(VEC_LVL[i], VEC_CYC[i]);
      check(VEC_EXP[i], $sformatf("R%0d", VEC_REQ[i]), $sformatf("vector %0d", i));
    end

    // R1: asynchronous reset from high state, then full delay again
    hold(1'b1, 40);
    check(1'b1, "R1", "high before reset");
    rst_n = 1'b0;
    #1;
    check(1'b0, "R1", "reset clears output at once");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (MAXC + 2) @(negedge clk);
    check(1'b0, "R1", "counter cleared by reset, still low");
    @(negedge clk);
    check(1'b1, "R2", "rise after MAX+3 from reset");

    // R7: 25-clock high pulse from low state is rejected
    hold(1'b0, 40);
    check(1'b0, "R7", "settled low");
    noisy_i = 1'b1;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      check(1'b0, "R7", "during high pulse");
    end
    noisy_i = 1'b0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      check(1'b0, "R7", "after high pulse");
    end

    // R7: 25-clock low pulse from saturated high state is rejected
    hold(1'b1, 40);
    check(1'b1, "R7", "settled high");
    noisy_i = 1'b0;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      check(1'b1, "R7", "during low pulse");
    end
    noisy_i = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      check(1'b1, "R7", "after low pulse");
    end

    // R5: timed fall from saturated high
    hold(1'b0, MAXC + 2);
    check(1'b1, "R5", "one clock before fall");
    @(negedge clk);
    check(1'b0, "R5", "fall after MAX+3");

    finish_run();
  end

endmodule